// File: doc/BRIEF.md
# Adaptive On-Time Switching Sequencer

This block is the digital sequencer of a constant on-time step-down controller. It has no oscillator. A switching cycle begins when an external comparator reports that the feedback voltage has dropped below the reference. The high-side gate enable is then driven for an on-time that the block computes from digitised input and output voltage codes. Because that on-time tracks the ratio of output to input voltage, the switching frequency stays close to a fixed value across the input range.

After each on pulse, both gate enables stay low for a dead-time. The low side is then switched on. The next high-side pulse cannot begin until three conditions hold: a minimum off-time has elapsed, the feedback comparator asks for energy again, and the valley overcurrent flag is clear. A second, shorter dead-time separates low-side turn-off from high-side turn-on. A frequency-select input switches both the on-time constant and the minimum off-time between a low-frequency and a high-frequency operating point. Dropping the enable input parks the sequencer in an idle state with both gates off.

All timing is counted in system clock cycles. At the default 5 ns clock, the derived counts are as follows: the high-to-low dead-time is 10 cycles, the low-to-high dead-time is 8 cycles, and the minimum off-time is 57 cycles at the low setting and 44 cycles at the high setting. The on-time constant is 520 at the low setting and 187 at the high setting. The voltage codes are treated as ratios, so their common scale cancels out.

Top module: `aot_pwm_seq`

## Requirements
- R1: When rst_n is low, or while en is low, hs_gate and ls_gate are 0. Lowering en forces both gates to 0 in the same cycle. The sequencer then restarts from idle, and after en returns high no gate turns on until fb_below_ref is seen high.
- R2: From idle, if fb_below_ref is high at a clock edge, hs_gate is 1 in the cycle after that edge.
- R3: Each high-side pulse lasts N cycles, where N = floor(K * vout_code / vin_code). K is 520 when fsel_high = 0 and 187 when fsel_high = 1.
- R4: N is clamped to the range 1 to TON_MAX, where TON_MAX is 600 by default. If vin_code = 0, N = TON_MAX. A quotient of 0 gives N = 1. A quotient above TON_MAX gives N = TON_MAX.
- R5: After hs_gate falls, both gates are 0 for exactly 10 cycles before ls_gate rises.
- R6: The interval with hs_gate low between two pulses is never shorter than the minimum off-time: 57 cycles when fsel_high = 0 and 44 cycles when fsel_high = 1. When fb_below_ref is held high, the interval equals that value exactly, so ls_gate is high for 39 or 26 cycles respectively. Both gates are 0 for exactly 8 cycles between ls_gate falling and hs_gate rising.
- R7: fb_below_ref has no effect while hs_gate is high, so the pulse width is unchanged. While fb_below_ref stays low after the minimum off-time, ls_gate stays 1 and hs_gate stays 0. When fb_below_ref is then seen high at an edge, ls_gate is 0 in the next cycle.
- R8: While valley_ocp is high, the low-side period is held and no new pulse starts. valley_ocp has no effect on the length of a high-side pulse. When valley_ocp clears with fb_below_ref high, ls_gate falls in the next cycle and hs_gate rises 8 cycles after that.
- R9: The voltage codes and fsel_high are sampled at the edge where a pulse starts. Code changes during a pulse do not change its width, but they do apply to the next pulse.
- R10: hs_gate and ls_gate are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds both gates off and clears the timers |
| fb_below_ref | input | 1 | Feedback comparator output, high when feedback is below the reference |
| valley_ocp | input | 1 | Valley overcurrent flag, checked during the low-side period |
| fsel_high | input | 1 | 0 selects the low-frequency point, 1 selects the high-frequency point |
| vin_code | input | CODE_W | Digitised input voltage |
| vout_code | input | CODE_W | Digitised output voltage |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
Each gate output is decoded from the phase register, so any decision made at an edge appears one cycle later. The exception is the enable input, which clears both gates in the same cycle. Because of this, a start request or a cleared overcurrent flag is checked one cycle after the edge that samples it, and the following high-side turn-on is checked exactly 8 cycles after that. The bench drives inputs and samples outputs just after the falling edge. A falling-edge monitor measures every pulse width, dead-time and off interval in whole cycles. Widths are compared on the second pulse after enable, so that the minimum off-time is measured between two real pulses.

// File: rtl/aot_pwm_pkg.sv
package aot_pwm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_HIGH  = 3'd1,
    PH_DT_HL = 3'd2,
    PH_LOW   = 3'd3,
    PH_DT_LH = 3'd4
  } phase_t;

  // Converts a duration in ns to whole clock cycles, rounding up.
  function automatic int ns_to_cyc(input int dur_ns, input int clk_ns);
    return (dur_ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/aot_ontime_calc.sv
module aot_ontime_calc #(
  parameter int CODE_W  = 8,
  parameter int TON_W   = 10,
  parameter int K_LO    = 520,
  parameter int K_HI    = 187,
  parameter int TON_MAX = 600
) (
  input  logic              fsel_high,
  input  logic [CODE_W-1:0] vin_code,
  input  logic [CODE_W-1:0] vout_code,
  output logic [TON_W-1:0]  ton_cyc
);
  localparam int K_MAX  = (K_LO > K_HI) ? K_LO : K_HI;
  localparam int K_W    = $clog2(K_MAX + 1);
  localparam int PROD_W = CODE_W + K_W;

  logic [K_W-1:0]    k_sel;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  assign k_sel = fsel_high ? K_W'(K_HI) : K_W'(K_LO);
  assign prod  = PROD_W'(k_sel) * PROD_W'(vout_code);

  always_comb begin
    quot = '0;
    if (vin_code != '0) quot = prod / PROD_W'(vin_code);
    if (vin_code == '0 || quot > PROD_W'(TON_MAX)) ton_cyc = TON_W'(TON_MAX);
    else if (quot == '0)                           ton_cyc = TON_W'(1);
    else                                           ton_cyc = TON_W'(quot);
  end

  // R4
  always_comb begin
    if (!$isunknown({fsel_high, vin_code, vout_code})) begin
      ton_range_chk: assert (ton_cyc >= TON_W'(1) && ton_cyc <= TON_W'(TON_MAX))
        else $error("on-time count out of range");
    end
  end

endmodule

// File: rtl/aot_dwell_timer.sv
module aot_dwell_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/aot_pwm_seq.sv
module aot_pwm_seq
  import aot_pwm_pkg::*;
#(
  parameter int CLK_NS     = 5,
  parameter int DT_HL_NS   = 50,
  parameter int DT_LH_NS   = 40,
  parameter int TOFF_LO_NS = 285,
  parameter int TOFF_HI_NS = 216,
  parameter int CODE_W     = 8,
  parameter int K_LO       = 520,
  parameter int K_HI       = 187,
  parameter int TON_MAX    = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fb_below_ref,
  input  logic              valley_ocp,
  input  logic              fsel_high,
  input  logic [CODE_W-1:0] vin_code,
  input  logic [CODE_W-1:0] vout_code,
  output logic              hs_gate,
  output logic              ls_gate
);
  localparam int DT_HL_CYC   = ns_to_cyc(DT_HL_NS, CLK_NS);
  localparam int DT_LH_CYC   = ns_to_cyc(DT_LH_NS, CLK_NS);
  localparam int TOFF_LO_CYC = ns_to_cyc(TOFF_LO_NS, CLK_NS);
  localparam int TOFF_HI_CYC = ns_to_cyc(TOFF_HI_NS, CLK_NS);
  localparam int TOFF_MAX    = (TOFF_LO_CYC > TOFF_HI_CYC) ? TOFF_LO_CYC : TOFF_HI_CYC;
  localparam int SPAN_MAX    = (TON_MAX > TOFF_MAX) ? TON_MAX : TOFF_MAX;
  localparam int TIM_W       = $clog2(SPAN_MAX + 1);
  localparam int TON_W       = $clog2(TON_MAX + 1);
  // Off timer covers high-side fall to low-side fall; the last dead-time completes the minimum off.
  localparam int OFF_LD_LO   = TOFF_LO_CYC - DT_LH_CYC - 1;
  localparam int OFF_LD_HI   = TOFF_HI_CYC - DT_LH_CYC - 1;

  phase_t           ph_q, ph_d;
  logic [TON_W-1:0] ton_cyc;
  logic             ph_load, off_load;
  logic [TIM_W-1:0] ph_val;
  logic             ph_done, off_done;

  aot_ontime_calc #(
    .CODE_W (CODE_W),
    .TON_W  (TON_W),
    .K_LO   (K_LO),
    .K_HI   (K_HI),
    .TON_MAX(TON_MAX)
  ) u_ontime (
    .fsel_high(fsel_high),
    .vin_code (vin_code),
    .vout_code(vout_code),
    .ton_cyc  (ton_cyc)
  );

  aot_dwell_timer #(.W(TIM_W)) u_phase_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!en),
    .load    (ph_load),
    .load_val(ph_val),
    .done    (ph_done)
  );

  aot_dwell_timer #(.W(TIM_W)) u_off_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!en),
    .load    (off_load),
    .load_val(fsel_high ? TIM_W'(OFF_LD_HI) : TIM_W'(OFF_LD_LO)),
    .done    (off_done)
  );

  always_comb begin
    ph_d     = ph_q;
    ph_load  = 1'b0;
    ph_val   = '0;
    off_load = 1'b0;
    case (ph_q)
      PH_IDLE: if (fb_below_ref) begin
        ph_d    = PH_HIGH;
        ph_load = 1'b1;
        ph_val  = TIM_W'(ton_cyc) - 1'b1;
      end
      PH_HIGH: if (ph_done) begin
        ph_d     = PH_DT_HL;
        ph_load  = 1'b1;
        ph_val   = TIM_W'(DT_HL_CYC - 1);
        off_load = 1'b1;
      end
      PH_DT_HL: if (ph_done) ph_d = PH_LOW;
      PH_LOW: if (off_done && fb_below_ref && !valley_ocp) begin
        ph_d    = PH_DT_LH;
        ph_load = 1'b1;
        ph_val  = TIM_W'(DT_LH_CYC - 1);
      end
      PH_DT_LH: if (ph_done) begin
        ph_d    = PH_HIGH;
        ph_load = 1'b1;
        ph_val  = TIM_W'(ton_cyc) - 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ph_q <= PH_IDLE;
    else if (!en) ph_q <= PH_IDLE;
    else          ph_q <= ph_d;
  end

  assign hs_gate = en && (ph_q == PH_HIGH);
  assign ls_gate = en && (ph_q == PH_LOW);

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  // R2
  hs_start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> $past(fb_below_ref));

  // R5
  ls_gap_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_gate) |-> !ls_gate);

  // R6
  hs_gap_after_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> !$past(ls_gate));

  // R8
  ocp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_gate && valley_ocp) |=> (ls_gate || !en));

  // R1
  restart_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!en) && en) |-> (!hs_gate && !ls_gate));

endmodule

// File: tb/aot_pwm_seq_tb.sv
`timescale 1ns/1ps
module aot_pwm_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       fb = 1'b0;
  logic       ocp = 1'b0;
  logic       fsel = 1'b0;
  logic [7:0] vin = 8'd120;
  logic [7:0] vout = 8'd18;
  logic       hs, ls;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  aot_pwm_seq u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .fb_below_ref(fb), .valley_ocp(ocp),
    .fsel_high(fsel), .vin_code(vin), .vout_code(vout),
    .hs_gate(hs), .ls_gate(ls)
  );

  // Falling-edge monitor measuring widths in whole cycles
  int  hs_run, ls_run, low_run, both_run;
  int  last_hs_w, last_ls_w, last_off, last_dthl, last_dtlh;
  int  pulses, overlap;
  bit  prev_hs, prev_ls;

  always @(negedge clk) begin
    if (hs && ls) overlap++;
    if (!rst_n || !en) begin
      hs_run = 0; ls_run = 0; low_run = 0; both_run = 0; pulses = 0;
      prev_hs = 0; prev_ls = 0;
    end else begin
      if (hs) begin
        if (!prev_hs) begin last_off = low_run; last_dtlh = both_run; hs_run = 0; end
        hs_run++;
      end else begin
        if (prev_hs) begin last_hs_w = hs_run; pulses++; low_run = 0; end
        low_run++;
      end
      if (ls) begin
        if (!prev_ls) begin last_dthl = both_run; ls_run = 0; end
        ls_run++;
      end else if (prev_ls) last_ls_w = ls_run;
      if (!hs && !ls) both_run++; else both_run = 0;
      prev_hs = hs; prev_ls = ls;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulses(input int n);
    for (int i = 0; i < 5000 && pulses < n; i++) tick(1);
  endtask

  task automatic restart(input bit fs, input int vi, input int vo, input bit f);
    en = 0; fb = 0; ocp = 0;
    tick(3);
    fsel = fs; vin = vi[7:0]; vout = vo[7:0]; fb = f; en = 1;
  endtask

  task automatic t_reset();
    chk("R1 reset hs", hs, 0);
    chk("R1 reset ls", ls, 0);
  endtask

  task automatic t_latency();
    restart(0, 120, 18, 0);
    tick(5);
    chk("R2 idle hs before request", hs, 0);
    fb = 1;
    tick(1);
    chk("R2 hs one cycle after request", hs, 1);
  endtask

  task automatic t_steady(input bit fs, input int vi, input int vo,
                          input int e_ton, input int e_off);
    restart(fs, vi, vo, 1);
    wait_pulses(2);
    chk("R3 on width", last_hs_w, e_ton);
    chk("R5 hs-to-ls dead", last_dthl, 10);
    chk("R6 ls-to-hs dead", last_dtlh, 8);
    chk("R6 off interval", last_off, e_off);
    chk("R6 ls width", last_ls_w, e_off - 18);
  endtask

  task automatic t_clamp(input bit fs, input int vi, input int vo, input int e_ton);
    restart(fs, vi, vo, 1);
    wait_pulses(2);
    chk("R4 clamped on width", last_hs_w, e_ton);
  endtask

  task automatic t_fb_ignore();
    restart(0, 120, 18, 1);
    tick(1);
    chk("R2 pulse started", hs, 1);
    fb = 0;
    tick(10);
    fb = 1;
    tick(3);
    fb = 0;
    wait_pulses(1);
    chk("R7 width unchanged by fb", last_hs_w, 78);
    tick(150);
    chk("R7 ls held while fb low", ls, 1);
    chk("R7 hs held off while fb low", hs, 0);
    chk("R7 no extra pulse", pulses, 1);
    fb = 1;
    tick(1);
    chk("R7 ls falls next cycle", ls, 0);
    tick(7);
    chk("R6 hs still off in dead", hs, 0);
    tick(1);
    chk("R6 hs on after 8 dead cycles", hs, 1);
  endtask

  task automatic t_ocp();
    restart(0, 120, 18, 1);
    ocp = 1;
    wait_pulses(1);
    chk("R8 ocp ignored during hs", last_hs_w, 78);
    tick(120);
    chk("R8 ls held by ocp", ls, 1);
    chk("R8 hs held off by ocp", hs, 0);
    chk("R8 no pulse during ocp", pulses, 1);
    ocp = 0;
    tick(1);
    chk("R8 ls falls after clear", ls, 0);
    tick(7);
    chk("R8 hs still off", hs, 0);
    tick(1);
    chk("R8 hs on after clear", hs, 1);
  endtask

  task automatic t_sample();
    restart(0, 120, 18, 1);
    tick(5);
    vout = 8'd36;
    wait_pulses(1);
    chk("R9 width uses start codes", last_hs_w, 78);
    wait_pulses(2);
    chk("R9 next pulse uses new codes", last_hs_w, 156);
  endtask

  task automatic t_disable();
    restart(0, 120, 18, 1);
    tick(10);
    chk("R1 in pulse", hs, 1);
    en = 0;
    #1;
    chk("R1 hs drops with en", hs, 0);
    tick(1);
    chk("R1 ls stays low", ls, 0);
    tick(3);
    fb = 0; en = 1;
    tick(20);
    chk("R1 no restart without request hs", hs, 0);
    chk("R1 no restart without request ls", ls, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    tick(2);
    t_reset();
    rst_n = 1;
    tick(2);
    t_reset();
    t_latency();
    t_steady(0, 120, 18, 78, 57);
    t_steady(1, 120, 18, 28, 44);
    t_steady(0, 200, 100, 260, 57);
    t_clamp(0, 0, 18, 600);
    t_clamp(1, 50, 0, 1);
    t_clamp(0, 1, 255, 600);
    t_fb_ignore();
    t_ocp();
    t_sample();
    t_disable();
    chk("R10 gates never overlap", overlap, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule